// File: doc/BRIEF.md
# Serial Presence-Detect Byte Store with Block Write Protection

This block models the byte store of a module-configuration memory: 512 bytes (addresses 0x000 to 0x1FF) held in registers and reached through a simple one-command-per-cycle request port of the kind a serial slave front end would drive. The store is divided into four 128-byte blocks. The block number is the top two address bits, addr[8:7]. Each of the three lower blocks, which cover bytes 0 to 383, carries a protect flag that software can set and clear again. The top block, bytes 384 to 511, is kept free for end-user data and can never be protected.

A write to an unprotected block stores the byte and then starts a busy period of `WRITE_CYCLES` clock cycles, which stands in for the cell programming time. While that period runs, every request is refused. A write to a protected block is acknowledged, but its data is dropped and a sticky rejection flag is set. Every byte reads 0x00 after reset, and that includes the reserved range 0x100 to 0x13F.

Command codes on `req_op` are 0 read, 1 write, 2 set the protect flag of block addr[8:7], 3 clear the protect flag of block addr[8:7], and 4 clear every protect flag. Codes 5 to 7 are acknowledged and have no effect. Each response is registered: `req_ack`, `req_nack`, `rsp_valid` and `rsp_data` reflect a request sampled at one rising edge and change just after that edge.

Top module: `spd_store`

## Requirements
- R1: After reset every address reads 0x00, including 0x100 to 0x13F, no block is protected, `busy` is 0 and `wr_rejected` is 0.
- R2: A read (op 0) that is accepted returns `req_ack`=1, `rsp_valid`=1 and the stored byte on `rsp_data`, all valid in the cycle after the request edge.
- R3: A write (op 1) to an unprotected block is acknowledged and stores `req_wdata` at `req_addr`, so a later read of that address returns it.
- R4: After a stored write, `busy` is high for exactly `WRITE_CYCLES` cycles. During that time every request gets `req_nack`=1 and `req_ack`=0 and has no effect.
- R5: Op 2 protects block addr[8:7]. A later write to that block is acknowledged, leaves the data unchanged, starts no busy period and sets `wr_rejected`.
- R6: Op 3 removes the protection of block addr[8:7], so writes to that block are stored again.
- R7: Op 4 removes the protection of every block at once.
- R8: Block 3 (addresses 384 to 511) ignores op 2, and writes to it are always stored.
- R9: Once `wr_rejected` is set, it stays at 1 until reset.
- R10: Protecting one block has no effect on writes to any other block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Command code (0 read, 1 write, 2 protect, 3 unprotect, 4 unprotect all) |
| req_addr | input | 9 | Byte address; bits [8:7] select the block |
| req_wdata | input | 8 | Write data |
| req_ack | output | 1 | Previous-cycle request accepted |
| req_nack | output | 1 | Previous-cycle request refused because the store was busy |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 8 | Read data |
| busy | output | 1 | Write time in progress |
| wr_rejected | output | 1 | Sticky: a write hit a protected block |

## Verification
The hardest cases to reach are the ones that depend on protection and busy time overlapping in a particular order. A request must arrive on the very edge after a stored write, when busy has just risen. A protected write must also be seen to start no busy period, which can only be checked after earlier busy periods have fully drained. The bench issues a stored write and then immediately follows it with both a read and a write. It counts the busy cycles sample by sample and afterwards reads back the address the refused write aimed at. Protection is toggled per block and then cleared as a whole, with reads after each step that show which bytes changed.

// File: rtl/spd_pkg.sv
package spd_pkg;
    localparam int SPD_ADDR_W = 9;
    localparam int SPD_DATA_W = 8;
    localparam int SPD_BLK_W  = 2;
    localparam int SPD_OP_W   = 3;

    typedef enum logic [SPD_OP_W-1:0] {
        OP_READ     = 3'd0,
        OP_WRITE    = 3'd1,
        OP_PROT_SET = 3'd2,
        OP_PROT_CLR = 3'd3,
        OP_PROT_ALL = 3'd4
    } spd_op_e;

    typedef struct packed {
        logic do_read;
        logic do_store;
        logic do_reject;
        logic do_set;
        logic do_clr;
        logic do_clr_all;
    } spd_cmd_t;

    function automatic spd_cmd_t spd_decode(input logic accept, input logic [SPD_OP_W-1:0] op,
                                            input logic blk_locked);
        spd_cmd_t c;
        c = '0;
        if (accept) begin
            case (op)
                OP_READ:     c.do_read    = 1'b1;
                OP_WRITE:    begin
                    c.do_store  = !blk_locked;
                    c.do_reject = blk_locked;
                end
                OP_PROT_SET: c.do_set     = 1'b1;
                OP_PROT_CLR: c.do_clr     = 1'b1;
                OP_PROT_ALL: c.do_clr_all = 1'b1;
                default:     c = '0;
            endcase
        end
        return c;
    endfunction
endpackage

// File: rtl/spd_prot.sv
module spd_prot #(
    parameter int BLK_W       = 2,
    parameter int PROT_BLOCKS = 3,
    localparam int N_BLK      = 2 ** BLK_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic             clr_all,
    input  logic [BLK_W-1:0] blk,
    output logic [N_BLK-1:0] mask
);
    for (genvar b = 0; b < N_BLK; b++) begin : g_flag
        if (b < PROT_BLOCKS) begin : g_lockable
            logic flag_q;
            always_ff @(posedge clk) begin
                if (rst || clr_all) begin
                    flag_q <= 1'b0;
                end else if (set_en && blk == BLK_W'(b)) begin
                    flag_q <= 1'b1;
                end else if (clr_en && blk == BLK_W'(b)) begin
                    flag_q <= 1'b0;
                end
            end
            assign mask[b] = flag_q;
        end else begin : g_open
            assign mask[b] = 1'b0;
        end
    end
endmodule

// File: rtl/spd_timer.sv
module spd_timer #(
    parameter int WRITE_CYCLES = 1250000,
    localparam int CNT_W       = $clog2(WRITE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(WRITE_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/spd_array.sv
module spd_array #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8,
    parameter int BLK_W  = 2,
    localparam int OFF_W = ADDR_W - BLK_W,
    localparam int N_BLK = 2 ** BLK_W,
    localparam int BLK_BYTES = 2 ** OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [BLK_W-1:0] blk;
    logic [OFF_W-1:0] off;
    logic [DATA_W-1:0] blk_rd [N_BLK];

    assign blk = addr[ADDR_W-1:OFF_W];
    assign off = addr[OFF_W-1:0];

    for (genvar b = 0; b < N_BLK; b++) begin : g_blk
        logic [DATA_W-1:0] cells [BLK_BYTES];
        logic              blk_we;
        assign blk_we = we && (blk == BLK_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < BLK_BYTES; i++) cells[i] <= '0;
            end else if (blk_we) begin
                cells[off] <= wdata;
            end
        end
        assign blk_rd[b] = cells[off];
    end

    assign rdata = blk_rd[blk];
endmodule

// File: rtl/spd_store.sv
module spd_store
    import spd_pkg::*;
#(
    parameter int ADDR_W       = SPD_ADDR_W,
    parameter int DATA_W       = SPD_DATA_W,
    parameter int BLK_W        = SPD_BLK_W,
    parameter int PROT_BLOCKS  = 3,
    parameter int WRITE_CYCLES = 1250000,
    localparam int N_BLK       = 2 ** BLK_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [SPD_OP_W-1:0] req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                req_ack,
    output logic                req_nack,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_data,
    output logic                busy,
    output logic                wr_rejected
);
    logic [BLK_W-1:0]  blk;
    logic [N_BLK-1:0]  prot_mask;
    logic              accept;
    spd_cmd_t          cmd;
    logic [DATA_W-1:0] arr_rd;

    assign blk    = req_addr[ADDR_W-1:ADDR_W-BLK_W];
    assign accept = req_valid && !busy;
    assign cmd    = spd_decode(accept, req_op, prot_mask[blk]);

    spd_prot #(.BLK_W(BLK_W), .PROT_BLOCKS(PROT_BLOCKS)) u_prot (
        .clk     (clk),
        .rst     (rst),
        .set_en  (cmd.do_set),
        .clr_en  (cmd.do_clr),
        .clr_all (cmd.do_clr_all),
        .blk     (blk),
        .mask    (prot_mask)
    );

    spd_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (cmd.do_store),
        .busy  (busy)
    );

    spd_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (cmd.do_store),
        .addr  (req_addr),
        .wdata (req_wdata),
        .rdata (arr_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_ack     <= 1'b0;
            req_nack    <= 1'b0;
            rsp_valid   <= 1'b0;
            rsp_data    <= '0;
            wr_rejected <= 1'b0;
        end else begin
            req_ack   <= accept;
            req_nack  <= req_valid && busy;
            rsp_valid <= cmd.do_read;
            if (cmd.do_read) rsp_data <= arr_rd;
            if (cmd.do_reject) wr_rejected <= 1'b1;
        end
    end
endmodule

// File: rtl/spd_store_chk.sv
module spd_store_chk #(
    parameter int ADDR_W = 9,
    parameter int BLK_W  = 2,
    localparam int N_BLK = 2 ** BLK_W
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [2:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_ack,
    input logic              req_nack,
    input logic              rsp_valid,
    input logic              busy,
    input logic              wr_rejected,
    input logic [N_BLK-1:0]  prot_mask
);
    logic [BLK_W-1:0] blk;
    assign blk = req_addr[ADDR_W-1:ADDR_W-BLK_W];

    assert_read_resp_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid && !busy && req_op == 3'd0 |=> req_ack && rsp_valid);

    assert_refuse_busy_R4: assert property (@(posedge clk) disable iff (rst)
        req_valid && busy |=> req_nack && !req_ack && !rsp_valid);

    assert_store_busy_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid && !busy && req_op == 3'd1 && !prot_mask[blk] |=> busy && req_ack);

    assert_locked_drop_R5: assert property (@(posedge clk) disable iff (rst)
        req_valid && !busy && req_op == 3'd1 && prot_mask[blk] |=> !busy && wr_rejected && req_ack);

    assert_top_block_open_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid && !busy && req_op == 3'd1 && blk == '1 |=> busy);

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        wr_rejected |=> wr_rejected);

    assert_clear_all_R7: assert property (@(posedge clk) disable iff (rst)
        req_valid && !busy && req_op == 3'd4 |=> prot_mask == '0);
endmodule

bind spd_store spd_store_chk #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_addr    (req_addr),
    .req_ack     (req_ack),
    .req_nack    (req_nack),
    .rsp_valid   (rsp_valid),
    .busy        (busy),
    .wr_rejected (wr_rejected),
    .prot_mask   (prot_mask)
);

// File: tb/spd_store_bench.sv
`timescale 1ns/1ps
module spd_store_bench;
    localparam int WC = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic [8:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       req_ack, req_nack, rsp_valid, busy, wr_rejected;
    logic [7:0] rsp_data;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    spd_store #(.WRITE_CYCLES(WC)) u_spd_store (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
        .req_nack(req_nack), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .busy(busy), .wr_rejected(wr_rejected)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [8:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(posedge clk); #1;
        end
    endtask

    task automatic read_chk(input string req, input logic [8:0] a, input logic [7:0] exp);
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd0; req_addr = a;
        @(posedge clk); #1;
        check({req, " ack"}, req_ack, 1);
        check({req, " rsp_valid"}, rsp_valid, 1);
        check({req, " data"}, rsp_data, exp);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic write_ok(input string req, input logic [8:0] a, input logic [7:0] d);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd1; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        check({req, " write ack"}, req_ack, 1);
        check({req, " busy rises"}, busy, 1);
        req_valid = 1'b0;
        wait_idle(n);
        check("R4 busy length", n, WC);
    endtask

    task automatic t_reset;
        check("R1 busy", busy, 0);
        check("R1 sticky", wr_rejected, 0);
        read_chk("R1 low", 9'h000, 8'h00);
        read_chk("R1 reserved start", 9'h100, 8'h00);
        read_chk("R1 reserved end", 9'h13F, 8'h00);
        read_chk("R1 top", 9'h1FF, 8'h00);
    endtask

    task automatic t_write_read;
        write_ok("R3", 9'h005, 8'hA5);
        write_ok("R3", 9'h1FF, 8'h3C);
        write_ok("R3", 9'h120, 8'h77);
        read_chk("R2 readback 005", 9'h005, 8'hA5);
        read_chk("R2 readback 1FF", 9'h1FF, 8'h3C);
        read_chk("R2 readback 120", 9'h120, 8'h77);
    endtask

    task automatic t_busy;
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd1; req_addr = 9'h0A0; req_wdata = 8'h5A;
        @(posedge clk); #1;
        @(negedge clk);
        req_addr = 9'h005; req_op = 3'd0;
        @(posedge clk); #1;
        check("R4 read nack", req_nack, 1);
        check("R4 read no ack", req_ack, 0);
        check("R4 no rsp", rsp_valid, 0);
        @(negedge clk);
        req_op = 3'd1; req_addr = 9'h0A1; req_wdata = 8'hEE;
        @(posedge clk); #1;
        check("R4 write nack", req_nack, 1);
        req_valid = 1'b0;
        wait_idle(n);
        read_chk("R4 refused write dropped", 9'h0A1, 8'h00);
        read_chk("R4 first write kept", 9'h0A0, 8'h5A);
    endtask

    task automatic t_protect;
        issue(3'd2, 9'h000, 8'h00);
        check("R5 prot ack", req_ack, 1);
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd1; req_addr = 9'h005; req_wdata = 8'h11;
        @(posedge clk); #1;
        check("R5 locked write ack", req_ack, 1);
        check("R5 no busy", busy, 0);
        check("R5 sticky set", wr_rejected, 1);
        @(negedge clk);
        req_valid = 1'b0;
        read_chk("R5 data kept", 9'h005, 8'hA5);
        write_ok("R10 other block", 9'h080, 8'h42);
        read_chk("R10 other block stored", 9'h080, 8'h42);
    endtask

    task automatic t_block3;
        issue(3'd2, 9'h180, 8'h00);
        write_ok("R8", 9'h1FF, 8'h99);
        read_chk("R8 top block stored", 9'h1FF, 8'h99);
    endtask

    task automatic t_unprot;
        issue(3'd3, 9'h07F, 8'h00);
        write_ok("R6", 9'h005, 8'h22);
        read_chk("R6 stored after clear", 9'h005, 8'h22);
    endtask

    task automatic t_clear_all;
        issue(3'd2, 9'h080, 8'h00);
        issue(3'd2, 9'h100, 8'h00);
        issue(3'd1, 9'h081, 8'hCC);
        check("R5 block1 locked no busy", busy, 0);
        read_chk("R5 block1 dropped", 9'h081, 8'h00);
        issue(3'd4, 9'h000, 8'h00);
        write_ok("R7 block1", 9'h081, 8'hCC);
        write_ok("R7 block2", 9'h101, 8'hDD);
        read_chk("R7 block1 stored", 9'h081, 8'hCC);
        read_chk("R7 block2 stored", 9'h101, 8'hDD);
        check("R9 sticky held", wr_rejected, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #1;
        t_reset();
        t_write_read();
        t_busy();
        t_protect();
        t_block3();
        t_unprot();
        t_clear_all();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule